// File: doc/BRIEF.md
# Multi-master I2C byte master

This block runs the master side of an I2C bus one command at a time. Software or a sequencer above it issues START, WRITE, READ and STOP commands. Each command completes with a single-cycle `done` pulse. A transaction is built from these commands:
- START,
- a WRITE carrying the 7-bit slave address with the direction bit (0 means the slave receives, 1 means the slave sends),
- any number of WRITE or READ byte commands,
- then STOP, or a further START for a repeated start.

Both bus wires are open-drain. The block only ever pulls a line low through `scl_oe` or `sda_oe`, and it reads the real levels back on `scl_i` and `sda_i`. Every SCL period is built from four quarters of `QDIV` clocks each.

A slave that holds SCL low freezes the bit timer until the wire really reads high. Every bit the master sends as a released 1 is compared with the wire. If the wire reads 0, another master has won the bus, and this block lets go of both lines at once. A built-in bus monitor tracks START and STOP conditions on the wires. While the bus belongs to someone else, a START request is turned away.

Top module: `i2c_mm_master`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `busy`, `done`, `rx_nack`, `arb_lost` and `bus_busy` are all 0.
- R2: A START command generates SDA falling while SCL is high, then leaves SCL held low with the bus owned. On a free bus it ends with `arb_lost` = 0, and the monitor then reports `bus_busy` = 1.
- R3: During WRITE and READ, SDA changes only while SCL is low, so no START or STOP appears on the wires. Every SCL high phase lasts at least 2*QDIV clocks.
- R4: WRITE sends `wr_data` most significant bit first, then releases SDA for a ninth clock. The level sampled in that ninth clock is stored in `rx_nack` (1 = not acknowledged). A not-acknowledged byte leaves the bus owned, waiting for STOP or START.
- R5: READ shifts in eight bits, most significant first, and shows them on `rd_data` from `done` until the next command. In the ninth clock SDA is pulled low when `rd_ack` = 1 (acknowledge) and released when `rd_ack` = 0. This level is still driven after `done`.
- R6: STOP generates SDA rising while SCL is high. Afterwards both lines are released and `bus_busy` returns to 0.
- R7: While the master has released SCL and SCL reads low, the master keeps SCL released and does not advance the bit. A stretched clock therefore still has a full-length high phase.
- R8: If SDA reads 0 at the sample point of a bit the master sends as released, `arb_lost` becomes 1 and both lines are released at once. The command ends with `done`, and the bus is no longer owned.
- R9: `bus_busy` is 1 from any START seen on the wires until the next STOP. A START command issued while `bus_busy` = 1 and the bus is not owned drives neither line, sets `arb_lost`, and pulses `done`. An accepted START clears `arb_lost`.
- R10: A START command while the bus is owned produces a repeated START with no STOP in between.
- R11: WRITE, READ or STOP while the bus is not owned completes with `done` and drives neither line.
- R12: Command code on `cmd`: 0 = START, 1 = STOP, 2 = WRITE, 3 = READ. A command is taken only when `cmd_valid` = 1 and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 2 | Command code (0 START, 1 STOP, 2 WRITE, 3 READ) |
| wr_data | input | 8 | Byte for WRITE |
| rd_ack | input | 1 | 1 = acknowledge the byte of this READ |
| rd_data | output | 8 | Byte received by the last READ |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_nack | output | 1 | Ninth-clock level after the last WRITE |
| arb_lost | output | 1 | Arbitration lost or START refused |
| bus_busy | output | 1 | Bus held between START and STOP |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
Arbitration loss and the release of SCL for the high phase fall in the same quarter. The bench provokes this with a second-master model that pulls SDA low under the first address bit. It then judges that both enables drop together, that `bus_busy` stays set until that master's STOP, and that a START issued in between is refused without touching the wires. Slave clock stretching also overlaps the sample point. Random transactions with random stretch lengths check that the received data stays correct and that no SCL high phase is shortened.

// File: rtl/i2c_mm_master.sv
module i2c_mm_master #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic [7:0] wr_data,
  input  logic       rd_ack,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done,
  output logic       rx_nack,
  output logic       arb_lost,
  output logic       bus_busy,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int QW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [QW-1:0] QTOP = QW'(QDIV - 1);
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_START, S_STOP, S_XFER} state_t;

  state_t        st;
  logic [QW-1:0] qcnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic          is_rd, ack_bit, scl_low, sda_low, owned, pscl, psda;

  wire stall    = (st != S_IDLE) && !scl_low && !scl_i;
  wire tick     = (st != S_IDLE) && !stall && (qcnt == '0);
  wire last_bit = (bitn == 4'd8);
  wire mtx      = is_rd ? last_bit : !last_bit;
  wire pull_val = is_rd ? ack_bit : !sh[7];

  assign busy    = (st != S_IDLE);
  assign scl_oe  = scl_low;
  assign sda_oe  = sda_low;
  assign rd_data = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      qcnt     <= QTOP;
      ph       <= 2'd0;
      bitn     <= 4'd0;
      sh       <= 8'd0;
      is_rd    <= 1'b0;
      ack_bit  <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      owned    <= 1'b0;
      pscl     <= 1'b1;
      psda     <= 1'b1;
      done     <= 1'b0;
      rx_nack  <= 1'b0;
      arb_lost <= 1'b0;
      bus_busy <= 1'b0;
    end else begin
      done <= 1'b0;
      pscl <= scl_i;
      psda <= sda_i;
      if (pscl && scl_i && psda && !sda_i)      bus_busy <= 1'b1;
      else if (pscl && scl_i && !psda && sda_i) bus_busy <= 1'b0;

      if (st == S_IDLE) begin
        if (cmd_valid) begin
          qcnt <= QTOP;
          ph   <= 2'd0;
          bitn <= 4'd0;
          case (cmd)
            C_START: begin
              arb_lost <= 1'b0;
              if (bus_busy && !owned) begin
                arb_lost <= 1'b1;
                done     <= 1'b1;
              end else begin
                st <= S_START;
              end
            end
            C_STOP: begin
              if (owned) st <= S_STOP;
              else       done <= 1'b1;
            end
            default: begin
              if (owned) begin
                st      <= S_XFER;
                is_rd   <= (cmd == C_READ);
                ack_bit <= rd_ack;
                if (cmd == C_WRITE) sh <= wr_data;
              end else begin
                done <= 1'b1;
              end
            end
          endcase
        end
      end else if (tick) begin
        qcnt <= QTOP;
        ph   <= ph + 2'd1;
        case (st)
          S_START: begin
            case (ph)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin
                scl_low <= 1'b1;
                owned   <= 1'b1;
                st      <= S_IDLE;
                done    <= 1'b1;
              end
            endcase
          end
          S_STOP: begin
            case (ph)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin
                owned <= 1'b0;
                st    <= S_IDLE;
                done  <= 1'b1;
              end
            endcase
          end
          default: begin
            case (ph)
              2'd0: sda_low <= mtx && pull_val;
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (mtx && !sda_low && !sda_i) begin
                  scl_low  <= 1'b0;
                  sda_low  <= 1'b0;
                  owned    <= 1'b0;
                  arb_lost <= 1'b1;
                  done     <= 1'b1;
                  st       <= S_IDLE;
                end else begin
                  if (!is_rd && last_bit) rx_nack <= sda_i;
                  if (is_rd && !last_bit) sh <= {sh[6:0], sda_i};
                end
              end
              default: begin
                scl_low <= 1'b1;
                if (last_bit) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
                end else begin
                  bitn <= bitn + 4'd1;
                  if (!is_rd) sh <= {sh[6:0], 1'b0};
                end
              end
            endcase
          end
        endcase
      end else if (!stall) begin
        qcnt <= qcnt - 1'b1;
      end
    end
  end

  // R2: the START edge on SDA happens while the SCL wire is high
  a_r2_start_under_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && $rose(sda_oe)) |-> scl_i);

  // R3: inside a byte, SDA drive moves only while SCL is held low
  a_r3_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && sda_low != $past(sda_low)) |-> (scl_low && $past(scl_low)));

  // R6: the STOP edge on SDA happens while the SCL wire is high
  a_r6_stop_under_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && $fell(sda_oe)) |-> scl_i);

  // R7: a released but stretched clock stays released
  a_r7_hold_while_stretched: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !scl_oe && !scl_i) |=> !scl_oe);

  // R8, R11: a master that does not own the bus drives nothing
  a_r8_quiet_when_not_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !owned) |-> (!scl_oe && !sda_oe));

  // R9: START on a bus held by another master is refused at once
  a_r9_refuse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && cmd == C_START && bus_busy && !owned)
      |=> (st == S_IDLE && arb_lost && done));

endmodule

// File: tb/sim_i2c_mm_master.sv
module sim_i2c_mm_master;
  localparam int QDIV = 4;
  localparam logic [6:0] ADDR = 7'h5A;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, rd_ack;
  logic [1:0] cmd;
  logic [7:0] wr_data, rd_data;
  logic busy, done, rx_nack, arb_lost, bus_busy, scl_oe, sda_oe;
  logic s_scl_low = 1'b0, s_sda_low = 1'b0, other_sda_low = 1'b0;
  logic scl, sda;

  always #10 clk = ~clk;

  assign scl = !(scl_oe || s_scl_low);
  assign sda = !(sda_oe || s_sda_low || other_sda_low);

  i2c_mm_master #(.QDIV(QDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .wr_data(wr_data),
    .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done), .rx_nack(rx_nack),
    .arb_lost(arb_lost), .bus_busy(bus_busy), .scl_i(scl), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  // ---------------- slave model ----------------
  logic ps = 1'b1, pd = 1'b1;
  int   sl_st = 0, sl_bit = 0, rx_cnt = 0, tx_idx = 0, str_cnt = 0;
  logic [7:0] sl_sh = 8'd0, sl_tx = 8'd0;
  logic sl_nk = 1'b0, m_ack = 1'b0;
  logic [7:0] rx_log [16];
  logic [7:0] tx_mem [16];
  int nack_at = 99, str_len = 0;

  always @(posedge clk) begin
    ps <= scl;
    pd <= sda;
    if (str_cnt > 0) begin
      str_cnt <= str_cnt - 1;
      if (str_cnt == 1) s_scl_low <= 1'b0;
    end
    if (ps && scl && pd && !sda) begin
      sl_st <= 1; sl_bit <= 0; s_sda_low <= 1'b0; rx_cnt <= 0; tx_idx <= 0; sl_nk <= 1'b0;
    end else if (ps && scl && !pd && sda) begin
      sl_st <= 0; sl_bit <= 0; s_sda_low <= 1'b0;
    end else if (!ps && scl) begin
      if (sl_st != 0) begin
        if (sl_bit < 8) sl_sh <= {sl_sh[6:0], sda};
        else m_ack <= !sda;
        sl_bit <= sl_bit + 1;
      end
    end else if (ps && !scl && sl_st != 0) begin
      if (str_len > 0) begin
        s_scl_low <= 1'b1;
        str_cnt <= str_len;
      end
      if (sl_bit == 8) begin
        if (sl_st == 1) s_sda_low <= (sl_sh[7:1] == ADDR);
        else if (sl_st == 2) begin
          rx_log[rx_cnt] <= sl_sh;
          rx_cnt <= rx_cnt + 1;
          sl_nk <= (rx_cnt == nack_at);
          s_sda_low <= (rx_cnt != nack_at);
        end else s_sda_low <= 1'b0;
      end else if (sl_bit == 9) begin
        sl_bit <= 0;
        if (sl_st == 1) begin
          if (sl_sh[7:1] == ADDR && sl_sh[0]) begin
            sl_st <= 3; sl_tx <= tx_mem[0]; tx_idx <= 1; s_sda_low <= !tx_mem[0][7];
          end else if (sl_sh[7:1] == ADDR) begin
            sl_st <= 2; s_sda_low <= 1'b0;
          end else begin
            sl_st <= 0; s_sda_low <= 1'b0;
          end
        end else if (sl_st == 2) begin
          s_sda_low <= 1'b0;
          if (sl_nk) sl_st <= 0;
        end else begin
          if (m_ack) begin
            sl_tx <= tx_mem[tx_idx]; s_sda_low <= !tx_mem[tx_idx][7]; tx_idx <= tx_idx + 1;
          end else begin
            sl_st <= 0; s_sda_low <= 1'b0;
          end
        end
      end else if (sl_st == 3 && sl_bit >= 1 && sl_bit <= 7) begin
        s_sda_low <= !sl_tx[7 - sl_bit];
      end
    end
  end

  // ---------------- wire monitor ----------------
  logic ms = 1'b1, md = 1'b1;
  int n_start = 0, n_stop = 0, n_short = 0, n_oe = 0, hcnt = 0;
  always @(posedge clk) begin
    ms <= scl;
    md <= sda;
    if (ms && scl && md && !sda) n_start <= n_start + 1;
    if (ms && scl && !md && sda) n_stop <= n_stop + 1;
    if (scl) hcnt <= hcnt + 1;
    else begin
      if (ms && hcnt < 2 * QDIV) n_short <= n_short + 1;
      hcnt <= 0;
    end
    if (scl_oe || sda_oe) n_oe <= n_oe + 1;
  end

  // ---------------- bench helpers ----------------
  int tests = 0, fails = 0;
  bit timeout = 1'b0;

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  function automatic logic exp_nack(input int i, input int nk);
    return (i == nk);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] d, input logic a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wr_data = d; rd_ack = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic do_write(input int n, input int nk, input int strl);
    logic [7:0] exp_b [8];
    int s0, p0, sh0, sent;
    nack_at = nk; str_len = strl; sh0 = n_short; sent = 0;
    issue(C_START, 8'h00, 1'b0);
    chk(!arb_lost && scl_oe, "R2 start owns bus", {arb_lost, scl_oe}, 2'b01);
    chk(bus_busy, "R2 monitor busy", bus_busy, 1);
    s0 = n_start; p0 = n_stop;
    issue(C_WRITE, addr_byte(ADDR, 1'b0), 1'b0);
    chk(!rx_nack, "R4 address acked", rx_nack, 0);
    for (int i = 0; i < n; i++) begin
      exp_b[i] = 8'($urandom);
      issue(C_WRITE, exp_b[i], 1'b0);
      sent++;
      chk(rx_nack == exp_nack(i, nk), "R4 byte ack status", rx_nack, exp_nack(i, nk));
      if (rx_nack) break;
    end
    chk(n_start == s0 && n_stop == p0, "R3 no edge while SCL high", n_start - s0 + n_stop - p0, 0);
    issue(C_STOP, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    chk(!bus_busy && !scl_oe && !sda_oe && n_stop == p0 + 1, "R6 stop frees bus",
        {bus_busy, scl_oe, sda_oe}, 0);
    chk(rx_cnt == sent, "R4 byte count", rx_cnt, sent);
    for (int i = 0; i < sent; i++)
      chk(rx_log[i] == exp_b[i], "R4 data msb first", rx_log[i], exp_b[i]);
    chk(n_short == sh0, strl > 0 ? "R7 stretched high phase" : "R3 high phase width", n_short - sh0, 0);
  endtask

  task automatic do_read(input int n, input int strl);
    int sh0;
    str_len = strl; sh0 = n_short;
    for (int i = 0; i < n; i++) tx_mem[i] = 8'($urandom);
    issue(C_START, 8'h00, 1'b0);
    chk(!arb_lost, "R2 start", arb_lost, 0);
    issue(C_WRITE, addr_byte(ADDR, 1'b1), 1'b0);
    chk(!rx_nack, "R4 read address acked", rx_nack, 0);
    for (int i = 0; i < n; i++) begin
      issue(C_READ, 8'h00, i != n - 1);
      chk(rd_data == tx_mem[i], "R5 read data", rd_data, tx_mem[i]);
      chk(sda_oe == (i != n - 1), "R5 ack drive", sda_oe, i != n - 1);
    end
    issue(C_STOP, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    chk(!bus_busy && !scl_oe && !sda_oe, "R6 stop after read", {bus_busy, scl_oe, sda_oe}, 0);
    chk(n_short == sh0, strl > 0 ? "R7 stretched read" : "R3 read high width", n_short - sh0, 0);
  endtask

  task automatic run_all();
    int o0, s0, p0;
    repeat (4) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done, rx_nack, arb_lost, bus_busy} == 7'd0, "R1 reset state",
        {scl_oe, sda_oe, busy, done, rx_nack, arb_lost, bus_busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: commands without ownership
    o0 = n_oe; s0 = n_start;
    issue(C_WRITE, 8'hFF, 1'b0);
    issue(C_STOP, 8'h00, 1'b0);
    chk(n_oe == o0 && n_start == s0 && !busy, "R11 no drive without bus", n_oe - o0, 0);

    // R12: command accepted only when idle (second request during busy is dropped)
    @(negedge clk); cmd_valid = 1'b1; cmd = C_START;
    @(negedge clk); cmd = C_STOP;
    @(negedge clk); cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(scl_oe && n_stop == 0, "R12 busy drops request", {scl_oe, 8'(n_stop)}, 9'h100);
    issue(C_STOP, 8'h00, 1'b0);

    do_write(3, 99, 0);
    do_write(3, 1, 0);
    do_read(2, 14);

    // address not acknowledged
    issue(C_START, 8'h00, 1'b0);
    issue(C_WRITE, addr_byte(7'h33, 1'b0), 1'b0);
    chk(rx_nack && scl_oe, "R4 address nack, bus kept", {rx_nack, scl_oe}, 2'b11);
    issue(C_STOP, 8'h00, 1'b0);

    // R10 repeated start
    tx_mem[0] = 8'hC3;
    issue(C_START, 8'h00, 1'b0);
    issue(C_WRITE, addr_byte(ADDR, 1'b0), 1'b0);
    issue(C_WRITE, 8'h3C, 1'b0);
    chk(rx_log[0] == 8'h3C, "R4 byte before restart", rx_log[0], 8'h3C);
    s0 = n_start; p0 = n_stop;
    issue(C_START, 8'h00, 1'b0);
    chk(n_start == s0 + 1 && n_stop == p0, "R10 repeated start", {8'(n_start - s0), 8'(n_stop - p0)}, 16'h0100);
    issue(C_WRITE, addr_byte(ADDR, 1'b1), 1'b0);
    issue(C_READ, 8'h00, 1'b0);
    chk(rd_data == 8'hC3, "R10 read after restart", rd_data, 8'hC3);
    issue(C_STOP, 8'h00, 1'b0);

    // R8 / R9 arbitration against a second master
    issue(C_START, 8'h00, 1'b0);
    @(negedge clk); cmd_valid = 1'b1; cmd = C_WRITE; wr_data = addr_byte(ADDR, 1'b0);
    @(negedge clk); cmd_valid = 1'b0; other_sda_low = 1'b1;
    while (!done) @(negedge clk);
    chk(arb_lost && !scl_oe && !sda_oe, "R8 lost and released", {arb_lost, scl_oe, sda_oe}, 3'b100);
    chk(bus_busy, "R9 busy kept for other master", bus_busy, 1);
    o0 = n_oe;
    issue(C_START, 8'h00, 1'b0);
    chk(arb_lost && n_oe == o0, "R9 start refused", {arb_lost, 8'(n_oe - o0)}, 9'h100);
    @(negedge clk); other_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_busy, "R9 other master stop", bus_busy, 0);
    issue(C_START, 8'h00, 1'b0);
    chk(!arb_lost && scl_oe, "R9 start after free clears flag", {arb_lost, scl_oe}, 2'b01);
    issue(C_STOP, 8'h00, 1'b0);

    // random mix
    for (int t = 0; t < 22; t++) begin
      int n, strl;
      n = 1 + int'($urandom % 4);
      strl = ($urandom % 2) ? 10 + int'($urandom % 15) : 0;
      if ($urandom % 2) do_write(n, ($urandom % 3 == 0) ? int'($urandom % 4) : 99, strl);
      else do_read(n, strl);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = 2'd0; wr_data = 8'd0; rd_ack = 1'b0;
    for (int i = 0; i < 16; i++) tx_mem[i] = 8'd0;
    fork
      run_all();
      begin repeat (180000) @(posedge clk); timeout = 1'b1; end
    join_any
    if (timeout) begin
      tests++; fails++;
      $display("FAIL watchdog R1..all act=timeout exp=finish");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule